// File: doc/BRIEF.md
# Configuration Request Packet Engine

This block turns one configuration access into a request packet and then waits for the answer. A requester presents a read or a write, with type 0 or type 1 routing, a target bus, a device/function number, a register offset, byte enables and write data. The engine builds a three-dword request header. It sends the header and any payload as 64-bit beats on an outbound stream, marking the first beat with start-of-packet and the last with end-of-packet. It then listens on an inbound completion stream and returns the low dword of the first beat that carries end-of-packet. If no such beat arrives within a parameterised number of cycles, it reports an error.

Only one request is in flight at a time. `req_ready` is high only while the engine is idle. The request is taken on a cycle where `req_valid` and `req_ready` are both high, and `done` pulses for one cycle when the request finishes. Writes also wait for a completion before `done`. Both streams are valid/ready. The outbound stream must hold its beat while `tx_ready` is low. The engine raises `rx_ready` only while it waits for a completion, and a beat counts only when `rx_valid` and `rx_ready` are both high.

Top module: `cfg_tlp_engine`

## Requirements
- R1: After reset, `req_ready` is 1 and `busy`, `tx_valid`, `rx_ready`, `done` and `err` are 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1. While the engine is busy, `req_ready` is 0 and the request inputs have no effect on the beats sent or on the result.
- R3: Header dword 0 holds the format/type code in bits 31:24 and the value 1 in bits 9:0; all other bits are 0. The code is 0x04 for a type 0 read, 0x44 for a type 0 write, 0x05 for a type 1 read and 0x45 for a type 1 write.
- R4: Header dword 1 holds the requester ID in bits 31:16, the tag in bits 15:8 and the byte enables (zero-extended) in bits 7:0. The requester ID is {`root_bus`, `req_devfn`}. The tag is 0x1D for reads and 0x10 for writes.
- R5: Header dword 2 holds `req_bus` in bits 31:24, `req_devfn` in bits 23:16, zeros in bits 15:12 and the offset in bits 11:0, with offset bits 1:0 forced to 0.
- R6: The first outbound beat is {dword 1, dword 0}, high half first, with `tx_sop`=1 and `tx_eop`=0.
- R7: For a read, or for a write whose cleared offset has bit 2 set, exactly two beats are sent. The second beat is {data, dword 2} with `tx_eop`=1, where data is the write data for a write and 0 for a read.
- R8: For a write whose cleared offset has bits 2:0 equal to 0, exactly three beats are sent. The second is {0, dword 2} with no markers. The third is {0, write data} with `tx_eop`=1.
- R9: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data`, `tx_sop` and `tx_eop` hold their values.
- R10: `rx_ready` is 1 only after the last outbound beat has been sent and until the request ends. A completion beat without `rx_eop` is consumed and does not end the request. The first beat with `rx_eop` ends it: `done` pulses in the next cycle with `err`=0 and `rdata` equal to bits 31:0 of that beat.
- R11: A write does not raise `done` until a completion beat with `rx_eop` has been taken.
- R12: If no end-of-packet beat is taken within TIMEOUT_CYCLES waiting cycles, `done` and `err` pulse together one cycle after the last waiting cycle, and `rdata` becomes 0xFFFFFFFF. An end-of-packet beat taken in the last waiting cycle still completes successfully.
- R13: `done` lasts one cycle. In that cycle `busy` is 0 and `req_ready` is 1, and `rdata` holds its value until the next request ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_bus | input | 8 | Root bus number, sampled when a request is taken |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_type1 | input | 1 | 1 = type 1 routing, 0 = type 0 |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Device/function number |
| req_offset | input | 12 | Register offset (bits 1:0 ignored) |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Request in flight |
| tx_valid | output | 1 | Outbound beat valid |
| tx_ready | input | 1 | Outbound sink ready |
| tx_data | output | 64 | Outbound beat |
| tx_sop | output | 1 | First beat of packet |
| tx_eop | output | 1 | Last beat of packet |
| rx_valid | input | 1 | Completion beat valid |
| rx_ready | output | 1 | Engine waiting for a completion |
| rx_data | input | 64 | Completion beat |
| rx_eop | input | 1 | Last beat of completion |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Timeout, valid with done |
| rdata | output | 32 | Returned dword |

## Verification
The hardest case to reach is the boundary of the completion timeout. The end-of-packet beat must land exactly in the last waiting cycle, where it still wins over the timeout, and a request with no answer must raise the error exactly one cycle later. The bench shortens the limit through the parameter. It counts falling edges from the moment the last outbound beat is taken, then either holds the inbound stream silent or drives the end-of-packet beat on the final counted edge. The bench also sweeps reads and writes of both routing types over offsets that mix quadword-aligned and unaligned values. Every sweep point runs under a different outbound stall pattern and a different number of inbound non-final beats.

// File: rtl/cfg_tlp_pkg.sv
package cfg_tlp_pkg;

  localparam logic [7:0] FT_RD0 = 8'h04;
  localparam logic [7:0] FT_WR0 = 8'h44;
  localparam logic [7:0] FT_RD1 = 8'h05;
  localparam logic [7:0] FT_WR1 = 8'h45;
  localparam logic [7:0] TAG_RD = 8'h1D;
  localparam logic [7:0] TAG_WR = 8'h10;
  localparam logic [9:0] LEN_ONE = 10'd1;

  localparam int BEAT_W   = 64;
  localparam int MAX_BEATS = 3;
  localparam int IDX_W    = $clog2(MAX_BEATS);

  typedef struct packed {
    logic [BEAT_W-1:0] data;
    logic              sop;
    logic              eop;
  } beat_t;

  typedef struct packed {
    logic        wr;
    logic        t1;
    logic [7:0]  root;
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [11:0] ofs;
    logic [3:0]  be;
    logic [31:0] wdata;
  } cfg_req_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } eng_state_t;

endpackage

// File: rtl/cfg_hdr_pack.sv
module cfg_hdr_pack
  import cfg_tlp_pkg::*;
(
  input  cfg_req_t                    req,
  output beat_t [MAX_BEATS-1:0]       beats,
  output logic  [IDX_W-1:0]           last_idx
);

  logic [7:0]  fmt;
  logic [7:0]  tag;
  logic [11:0] ofs_dw;
  logic [31:0] dw0, dw1, dw2;
  logic        quad_pad;
  logic [1:0]  ofs_lo_unused;

  assign ofs_lo_unused = req.ofs[1:0];

  always_comb begin
    unique case ({req.wr, req.t1})
      2'b00:   fmt = FT_RD0;
      2'b01:   fmt = FT_RD1;
      2'b10:   fmt = FT_WR0;
      default: fmt = FT_WR1;
    endcase
  end

  assign tag    = req.wr ? TAG_WR : TAG_RD;
  assign ofs_dw = {req.ofs[11:2], 2'b00};

  assign dw0 = {fmt, 14'd0, LEN_ONE};
  assign dw1 = {req.root, req.devfn, tag, 4'd0, req.be};
  assign dw2 = {req.bus, req.devfn, 4'd0, ofs_dw};

  assign quad_pad = req.wr && (ofs_dw[2:0] == 3'd0);

  always_comb begin
    beats[0] = '{data: {dw1, dw0}, sop: 1'b1, eop: 1'b0};
    if (quad_pad) begin
      beats[1] = '{data: {32'd0, dw2},       sop: 1'b0, eop: 1'b0};
      beats[2] = '{data: {32'd0, req.wdata}, sop: 1'b0, eop: 1'b1};
      last_idx = IDX_W'(2);
    end else begin
      beats[1] = '{data: {(req.wr ? req.wdata : 32'd0), dw2}, sop: 1'b0, eop: 1'b1};
      beats[2] = '0;
      last_idx = IDX_W'(1);
    end
  end

endmodule

// File: rtl/cfg_tx_beats.sv
module cfg_tx_beats
  import cfg_tlp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  beat_t [MAX_BEATS-1:0] beats_in,
  input  logic  [IDX_W-1:0]     last_in,
  input  logic                  tx_ready,
  output logic                  tx_valid,
  output logic  [BEAT_W-1:0]    tx_data,
  output logic                  tx_sop,
  output logic                  tx_eop,
  output logic                  sent
);

  beat_t [MAX_BEATS-1:0] bank;
  logic  [IDX_W-1:0]     idx;
  logic  [IDX_W-1:0]     last_q;
  logic                  active;
  beat_t                 cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank   <= '0;
      idx    <= '0;
      last_q <= '0;
      active <= 1'b0;
    end else if (load) begin
      bank   <= beats_in;
      idx    <= '0;
      last_q <= last_in;
      active <= 1'b1;
    end else if (active && tx_ready) begin
      if (idx == last_q) active <= 1'b0;
      else               idx    <= idx + 1'b1;
    end
  end

  assign cur      = bank[idx];
  assign tx_valid = active;
  assign tx_data  = cur.data;
  assign tx_sop   = active && cur.sop;
  assign tx_eop   = active && cur.eop;
  assign sent     = active && tx_ready && (idx == last_q);

endmodule

// File: rtl/cfg_cpl_wait.sv
module cfg_cpl_wait #(
  parameter int LIMIT = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic armed,
  input  logic rx_valid,
  input  logic rx_eop,
  output logic rx_ready,
  output logic finish,
  output logic fail
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;
  logic          hit;
  logic          expire;

  assign rx_ready = armed;
  assign hit      = armed && rx_valid && rx_eop;
  assign expire   = armed && (cnt == LAST);
  assign finish   = hit || expire;
  assign fail     = expire && !hit;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (start)             cnt <= '0;
    else if (armed && !finish)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/cfg_tlp_engine.sv
module cfg_tlp_engine
  import cfg_tlp_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 625000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  root_bus,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_type1,
  input  logic [7:0]  req_bus,
  input  logic [7:0]  req_devfn,
  input  logic [11:0] req_offset,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  output logic        busy,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [63:0] tx_data,
  output logic        tx_sop,
  output logic        tx_eop,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [63:0] rx_data,
  input  logic        rx_eop,
  output logic        done,
  output logic        err,
  output logic [31:0] rdata
);

  eng_state_t            state;
  cfg_req_t              req_in;
  beat_t [MAX_BEATS-1:0] beats;
  logic  [IDX_W-1:0]     last_idx;
  logic                  take, sent, finish, fail;
  logic                  rx_hi_unused;

  assign rx_hi_unused = ^rx_data[63:32];

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign take      = req_valid && req_ready;

  assign req_in = '{wr: req_write, t1: req_type1, root: root_bus, bus: req_bus,
                    devfn: req_devfn, ofs: req_offset, be: req_be, wdata: req_wdata};

  cfg_hdr_pack u_pack (
    .req      (req_in),
    .beats    (beats),
    .last_idx (last_idx)
  );

  cfg_tx_beats u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take),
    .beats_in (beats),
    .last_in  (last_idx),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_sop   (tx_sop),
    .tx_eop   (tx_eop),
    .sent     (sent)
  );

  cfg_cpl_wait #(.LIMIT(TIMEOUT_CYCLES)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (sent),
    .armed    (state == ST_WAIT),
    .rx_valid (rx_valid),
    .rx_eop   (rx_eop),
    .rx_ready (rx_ready),
    .finish   (finish),
    .fail     (fail)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: if (take) state <= ST_SEND;
        ST_SEND: if (sent) state <= ST_WAIT;
        ST_WAIT: if (finish) begin
          state <= ST_IDLE;
          done  <= 1'b1;
          err   <= fail;
          rdata <= fail ? 32'hFFFF_FFFF : rx_data[31:0];
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_tlp_engine_chk.sv
module cfg_tlp_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        busy,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [63:0] tx_data,
  input logic        tx_sop,
  input logic        tx_eop,
  input logic        rx_ready,
  input logic        done,
  input logic        err
);

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop));

  // R2
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready && tx_valid && tx_sop);

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R13
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready && !busy);

  // R12
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R10
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> busy && !tx_valid);

  // R6
  sop_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_sop |-> !tx_eop);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !tx_valid && !rx_ready);

endmodule

bind cfg_tlp_engine cfg_tlp_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .tx_sop    (tx_sop),
  .tx_eop    (tx_eop),
  .rx_ready  (rx_ready),
  .done      (done),
  .err       (err)
);

// File: tb/test_cfg_tlp_engine.sv
`timescale 1ns/1ps
module test_cfg_tlp_engine;

  localparam int LIMIT = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  root_bus = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_type1 = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [7:0]  req_devfn = '0;
  logic [11:0] req_offset = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        busy;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [63:0] tx_data;
  logic        tx_sop, tx_eop;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [63:0] rx_data = '0;
  logic        rx_eop = 1'b0;
  logic        done, err;
  logic [31:0] rdata;

  int tests = 0;
  int failed = 0;

  logic [63:0] cap_d [0:2];
  logic        cap_s [0:2];
  logic        cap_e [0:2];
  int          cap_n;

  always #5 clk = ~clk;

  cfg_tlp_engine #(.TIMEOUT_CYCLES(LIMIT)) i_cfg_tlp_engine (
    .clk(clk), .rst_n(rst_n), .root_bus(root_bus),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_type1(req_type1), .req_bus(req_bus), .req_devfn(req_devfn),
    .req_offset(req_offset), .req_be(req_be), .req_wdata(req_wdata),
    .busy(busy), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_eop(rx_eop), .done(done), .err(err), .rdata(rdata)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input bit t1, input logic [7:0] rb, input logic [7:0] bus,
                       input logic [7:0] dfn, input logic [11:0] ofs, input logic [3:0] be,
                       input logic [31:0] wd);
    @(negedge clk);
    chk("R2 ready before issue", {63'd0, req_ready}, 64'd1);
    req_write = wr; req_type1 = t1; root_bus = rb; req_bus = bus; req_devfn = dfn;
    req_offset = ofs; req_be = be; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 rx_ready low while sending", {63'd0, rx_ready}, 64'd0);
  endtask

  // collect outbound beats with a stall pattern; returns at the negedge after the last transfer
  task automatic capture(input int seed);
    int cyc = 0;
    cap_n = 0;
    while (cyc < 60 && !(cap_n > 0 && cap_e[cap_n-1])) begin
      tx_ready = ((cyc + seed) % 3) != 1;
      if (tx_valid && tx_ready && cap_n < 3) begin
        cap_d[cap_n] = tx_data; cap_s[cap_n] = tx_sop; cap_e[cap_n] = tx_eop;
        cap_n++;
      end
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    tx_ready = 1'b0;
  endtask

  task automatic check_beats(input bit wr, input bit t1, input logic [7:0] rb, input logic [7:0] bus,
                             input logic [7:0] dfn, input logic [11:0] ofs, input logic [3:0] be,
                             input logic [31:0] wd);
    logic [7:0]  fmt;
    logic [31:0] dw0, dw1, dw2;
    logic [11:0] oc;
    bit          qa;
    fmt = 8'h04 | (wr ? 8'h40 : 8'h00) | (t1 ? 8'h01 : 8'h00);
    dw0 = {fmt, 24'h000001};
    dw1 = {rb, dfn, (wr ? 8'h10 : 8'h1D), 4'h0, be};
    oc  = ofs & 12'hFFC;
    dw2 = {bus, dfn, 4'h0, oc};
    qa  = wr && (oc[2:0] == 3'd0);
    chk("R7/R8 beat count", 64'(cap_n), qa ? 64'd3 : 64'd2);
    chk("R3/R4/R6 first beat", cap_d[0], {dw1, dw0});
    chk("R6 first beat markers", {62'd0, cap_s[0], cap_e[0]}, 64'd2);
    if (qa) begin
      chk("R5/R8 header beat", cap_d[1], {32'd0, dw2});
      chk("R8 header beat markers", {62'd0, cap_s[1], cap_e[1]}, 64'd0);
      chk("R8 data beat", cap_d[2], {32'd0, wd});
      chk("R8 data beat markers", {62'd0, cap_s[2], cap_e[2]}, 64'd1);
    end else begin
      chk("R5/R7 last beat", cap_d[1], {(wr ? wd : 32'd0), dw2});
      chk("R7 last beat markers", {62'd0, cap_s[1], cap_e[1]}, 64'd1);
    end
    chk("R7/R8 no extra beat", {63'd0, tx_valid}, 64'd0);
  endtask

  task automatic complete(input int junk, input logic [31:0] val, input string tag);
    for (int j = 0; j < junk; j++) begin
      chk({tag, " rx_ready waiting"}, {63'd0, rx_ready}, 64'd1);
      rx_valid = 1'b1; rx_eop = 1'b0; rx_data = {32'h5A5A0000 + 32'(j), 32'hDEAD0000 + 32'(j)};
      @(posedge clk);
      @(negedge clk);
      rx_valid = 1'b0;
      chk({tag, " no done before eop"}, {63'd0, done}, 64'd0);
    end
    rx_valid = 1'b1; rx_eop = 1'b1; rx_data = {32'h77778888, val};
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0; rx_eop = 1'b0;
    chk({tag, " done after eop"}, {62'd0, done, err}, 64'd2);
    chk({tag, " rdata"}, 64'(rdata), 64'(val));
    chk("R13 idle in done cycle", {62'd0, busy, req_ready}, 64'd1);
    @(negedge clk);
    chk("R13 done single cycle", {63'd0, done}, 64'd0);
    chk("R13 rdata held", 64'(rdata), 64'(val));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk("R1 reset outputs", {58'd0, req_ready, busy, tx_valid, rx_ready, done, err}, 64'h20);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {58'd0, req_ready, busy, tx_valid, rx_ready, done, err}, 64'h20);

    // sweep: direction x routing x offsets (mix of quad-aligned and not)
    for (int wr = 0; wr < 2; wr++) begin
      for (int t1 = 0; t1 < 2; t1++) begin
        for (int k = 0; k < 8; k++) begin
          logic [11:0] ofs;
          logic [7:0]  rb, bus, dfn;
          logic [3:0]  be;
          logic [31:0] wd;
          ofs = 12'(k * 164 + (k % 4));
          rb  = 8'(8'h20 + 8'(k + t1 * 9));
          bus = 8'(8'h10 + 8'(k * 3 + wr));
          dfn = 8'(k * 37 + t1);
          be  = 4'((k * 5 + wr) & 15);
          wd  = 32'hA5000000 ^ 32'(k * 32'h01010101) ^ 32'(t1 << 20);
          issue(wr[0], t1[0], rb, bus, dfn, ofs, be, wd);
          capture(k + wr + t1);
          check_beats(wr[0], t1[0], rb, bus, dfn, ofs, be, wd);
          if (wr != 0) begin
            // R11: a write still waits for its completion
            @(negedge clk);
            @(negedge clk);
            chk("R11 write waits for completion", {62'd0, done, busy}, 64'd1);
          end
          complete(k % 3, 32'hC0DE0000 + 32'(k * 16 + wr * 2 + t1), wr != 0 ? "R11" : "R10");
        end
      end
    end

    // R2: request inputs change while busy have no effect
    issue(1'b0, 1'b1, 8'h3C, 8'h42, 8'h19, 12'h104, 4'hF, 32'h0);
    req_valid = 1'b1; req_write = 1'b1; req_type1 = 1'b0; req_bus = 8'hEE;
    req_devfn = 8'hEE; req_offset = 12'h000; req_be = 4'h1; req_wdata = 32'hFFFF0000; root_bus = 8'h99;
    chk("R2 not ready while busy", {63'd0, req_ready}, 64'd0);
    capture(0);
    check_beats(1'b0, 1'b1, 8'h3C, 8'h42, 8'h19, 12'h104, 4'hF, 32'h0);
    chk("R2 still not ready while waiting", {63'd0, req_ready}, 64'd0);
    req_valid = 1'b0;
    complete(1, 32'h13572468, "R2");
    chk("R2 busy request not taken", {62'd0, tx_valid, busy}, 64'd0);

    // R12: timeout with silent inbound stream
    issue(1'b0, 1'b0, 8'h01, 8'h02, 8'h08, 12'h010, 4'h3, 32'h0);
    capture(1);
    for (int i = 1; i <= LIMIT; i++) begin
      @(negedge clk);
      if (i < LIMIT) begin
        if (done) chk("R12 early timeout", {63'd0, done}, 64'd0);
      end else begin
        chk("R12 timeout done+err", {62'd0, done, err}, 64'd3);
        chk("R12 timeout rdata", 64'(rdata), 64'hFFFFFFFF);
      end
    end
    @(negedge clk);
    chk("R13 timeout pulse single", {62'd0, done, err}, 64'd0);

    // R12: eop in the final waiting cycle still succeeds (write, quad-aligned)
    issue(1'b1, 1'b0, 8'h05, 8'h06, 8'h10, 12'h020, 4'hC, 32'hBEEF0001);
    capture(2);
    check_beats(1'b1, 1'b0, 8'h05, 8'h06, 8'h10, 12'h020, 4'hC, 32'hBEEF0001);
    for (int i = 1; i < LIMIT; i++) begin
      @(negedge clk);
      if (done) chk("R12 early done", {63'd0, done}, 64'd0);
    end
    complete(0, 32'h600DF00D, "R12 last-cycle");

    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule